// File: doc/BRIEF.md
# SIR Infrared Pulse Modulator

This block turns a stream of bytes into the low-rate infrared transmit waveform. Each byte is framed as an asynchronous serial character. Every zero bit of that character is sent as one short light pulse at the start of the bit. A one bit sends nothing. The bit time and the pulse width both come from one staged configuration word. That word holds a rate divisor, a pulse-width count and a preamble count, which this encoding does not use.

Software writes the staged word and the mode bits while the PHY enable is low. The block copies the word into its active configuration on the rising edge of that enable. It checks the mode bits at the same moment. Only a valid slow-rate mode lets bytes through. Two fractional accumulators on the system clock produce the timing. One gives a baud tick at 16 × 115200 Hz and the other gives the pulse reference tick (8 MHz from a 40 MHz clock).

Top module: `sir_pulse_tx`

## Requirements
- R1: After reset `ir_tx` is low (with `tx_invert` low), `in_ready` is low, `cfg_active` is zero and `cfg_err`, `sir_on`, `mir_on` and `fir_on` are all low.
- R2: `cfg_next` is copied to `cfg_active` only at the clock edge that first sees `phy_en` high after it was low. While `phy_en` stays high or stays low, changes on `cfg_next` leave `cfg_active` unchanged. `cfg_active` is {divisor[15:10], width[9:5], preamble[4:0]}.
- R3: `mode_sel` is {fast[2], medium[1], slow[0]}. When `phy_en` rises, `cfg_err` is set if more than one mode bit is high and cleared otherwise. It then holds until the next rise. While `phy_en` is high, `sir_on`, `mir_on` and `fir_on` show the latched mode bits, even when `cfg_err` is set. They are low once `phy_en` is low.
- R4: `tx_en_st` equals `tx_en`, and `rx_en_st` equals `rx_en & (~tx_en | loopback)`.
- R5: A byte is sent as one start bit (0), eight data bits LSB first and one stop bit (1). A pulse starts at the beginning of each 0 bit, and a 1 bit gives no pulse.
- R6: Each bit lasts 16 × (divisor + 1) baud ticks.
- R7: A pulse lasts (width + 1) × (divisor + 1) reference ticks. If that is longer than a bit, it is cut off at the bit boundary.
- R8: `tx_invert` high inverts `ir_tx`, both while idle and during pulses.
- R9: `in_ready` is high only while `phy_en` is high, the latched mode is slow-rate only, `cfg_err` is low, `tx_en` is high and no byte is in flight. It stays low for the whole frame and rises in the cycle after the stop bit ends.
- R10: When `phy_en` is seen low mid-frame, the frame is dropped. From the next cycle the line is idle and `in_ready` is low.
- R11: If medium or fast mode alone is latched, `in_ready` stays low and no byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_next | input | 16 | Staged configuration word |
| phy_en | input | 1 | PHY enable; rising edge applies the staged word |
| mode_sel | input | 3 | Requested mode {fast, medium, slow} |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| loopback | input | 1 | Loopback request |
| tx_invert | input | 1 | Invert the transmit line |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Byte accepted when high with `in_valid` |
| ir_tx | output | 1 | Infrared transmit line |
| cfg_active | output | 16 | Active configuration read-back |
| cfg_err | output | 1 | Illegal mode combination latched |
| sir_on | output | 1 | Slow-rate mode active |
| mir_on | output | 1 | Medium-rate mode latched and PHY on |
| fir_on | output | 1 | Fast-rate mode latched and PHY on |
| tx_en_st | output | 1 | Transmit enable status |
| rx_en_st | output | 1 | Receive enable status |

## Verification
The bench compares `ir_tx` against a waveform it builds itself, cycle by cycle across a whole frame. A wrong bit counter, shift position or pulse counter therefore shows up as a mismatch in the first bit that it affects. A bad pulse counter gives a wrong pulse length within one bit time. A stuck busy flag keeps `in_ready` low one cycle past the stop bit. A latch that fires at the wrong moment shows on `cfg_active` in the cycle after `phy_en` is sampled.

// File: rtl/sir_pulse_tx.sv
module sir_pulse_tx #(
  parameter int BAUD_W = 6,
  parameter int PW_W   = 5,
  parameter int PRE_W  = 5,
  parameter int OVS    = 16,
  parameter int BT_NUM = 144,
  parameter int BT_DEN = 3125,
  parameter int RT_NUM = 1,
  parameter int RT_DEN = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [BAUD_W+PW_W+PRE_W-1:0]  cfg_next,
  input  logic                          phy_en,
  input  logic [2:0]                    mode_sel,
  input  logic                          tx_en,
  input  logic                          rx_en,
  input  logic                          loopback,
  input  logic                          tx_invert,
  input  logic                          in_valid,
  input  logic [7:0]                    in_data,
  output logic                          in_ready,
  output logic                          ir_tx,
  output logic [BAUD_W+PW_W+PRE_W-1:0]  cfg_active,
  output logic                          cfg_err,
  output logic                          sir_on,
  output logic                          mir_on,
  output logic                          fir_on,
  output logic                          tx_en_st,
  output logic                          rx_en_st
);

  localparam int CFG_W  = BAUD_W + PW_W + PRE_W;
  localparam int PL_W   = BAUD_W + PW_W + 1;
  localparam int SUB_W  = $clog2(OVS);
  localparam int BA_W   = $clog2(BT_NUM + BT_DEN) + 1;
  localparam int RA_W   = $clog2(RT_NUM + RT_DEN) + 1;
  localparam int FRAME  = 10;
  localparam int IDX_W  = $clog2(FRAME);

  logic [BA_W-1:0]   bacc;
  logic [RA_W-1:0]   racc;
  logic              phy_q;
  logic [2:0]        mode_q;
  logic              busy;
  logic [FRAME-1:0]  sh;
  logic [IDX_W-1:0]  idx;
  logic [BAUD_W-1:0] pre;
  logic [SUB_W-1:0]  sub;
  logic [PL_W-1:0]   prem;

  wire [BA_W-1:0] bsum  = bacc + BA_W'(BT_NUM);
  wire [RA_W-1:0] rsum  = racc + RA_W'(RT_NUM);
  wire            btick = bsum >= BA_W'(BT_DEN);
  wire            rtick = rsum >= RA_W'(RT_DEN);

  wire [BAUD_W-1:0] baud_a = cfg_active[CFG_W-1 -: BAUD_W];
  wire [PW_W-1:0]   pw_a   = cfg_active[PRE_W +: PW_W];
  wire [PL_W-1:0]   plen   = (PL_W'(pw_a) + PL_W'(1)) * (PL_W'(baud_a) + PL_W'(1));

  wire rise    = phy_en & ~phy_q;
  wire accept  = in_valid & in_ready;
  wire sub_end = (pre == baud_a) & (sub == SUB_W'(OVS - 1));

  assign in_ready = phy_q & (mode_q == 3'b001) & ~cfg_err & tx_en & ~busy;
  assign ir_tx    = (prem != '0) ^ tx_invert;
  assign sir_on   = phy_q & mode_q[0];
  assign mir_on   = phy_q & mode_q[1];
  assign fir_on   = phy_q & mode_q[2];
  assign tx_en_st = tx_en;
  assign rx_en_st = rx_en & (~tx_en | loopback);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bacc <= '0;
      racc <= '0;
    end else begin
      bacc <= btick ? bsum - BA_W'(BT_DEN) : bsum;
      racc <= rtick ? rsum - RA_W'(RT_DEN) : rsum;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phy_q      <= 1'b0;
      mode_q     <= '0;
      cfg_active <= '0;
      cfg_err    <= 1'b0;
    end else begin
      phy_q <= phy_en;
      if (rise) begin
        cfg_active <= cfg_next;
        mode_q     <= mode_sel;
        cfg_err    <= $countones(mode_sel) > 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      idx  <= '0;
      pre  <= '0;
      sub  <= '0;
      prem <= '0;
    end else if (!phy_en) begin
      busy <= 1'b0;
      prem <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      sh   <= {1'b1, in_data, 1'b0};
      idx  <= '0;
      pre  <= '0;
      sub  <= '0;
      prem <= plen;
    end else if (busy) begin
      if (rtick && prem != '0) prem <= prem - PL_W'(1);
      if (btick) begin
        if (pre != baud_a) begin
          pre <= pre + BAUD_W'(1);
        end else begin
          pre <= '0;
          if (!sub_end) begin
            sub <= sub + SUB_W'(1);
          end else begin
            sub <= '0;
            if (idx == IDX_W'(FRAME - 1)) begin
              busy <= 1'b0;
              prem <= '0;
            end else begin
              idx  <= idx + IDX_W'(1);
              sh   <= {1'b1, sh[FRAME-1:1]};
              prem <= sh[1] ? '0 : plen;
            end
          end
        end
      end
    end
  end

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(phy_en && !phy_q) |=> $stable(cfg_active));

  p_mode_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_err |-> $onehot0({fir_on, mir_on, sir_on}));

  p_pulse_zero_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prem != '0) |-> (busy && !sh[0]));

  p_ready_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (sir_on && !mir_on && !fir_on && !cfg_err && tx_en && ir_tx == tx_invert));

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_en |=> (!busy && prem == '0));

  p_no_take_other_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mir_on || fir_on) |-> !in_ready);

endmodule

// File: tb/sir_pulse_tx_tb_top.sv
module sir_pulse_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_next;
  logic        phy_en, tx_en, rx_en, loopback, tx_invert, in_valid;
  logic [2:0]  mode_sel;
  logic [7:0]  in_data;
  logic        in_ready, ir_tx, cfg_err, sir_on, mir_on, fir_on, tx_en_st, rx_en_st;
  logic [15:0] cfg_active;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sir_pulse_tx #(.BT_NUM(1), .BT_DEN(1), .RT_NUM(1), .RT_DEN(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_next(cfg_next), .phy_en(phy_en),
    .mode_sel(mode_sel), .tx_en(tx_en), .rx_en(rx_en), .loopback(loopback),
    .tx_invert(tx_invert), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .ir_tx(ir_tx), .cfg_active(cfg_active),
    .cfg_err(cfg_err), .sir_on(sir_on), .mir_on(mir_on), .fir_on(fir_on),
    .tx_en_st(tx_en_st), .rx_en_st(rx_en_st));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_cfg(input int b, input int w, input int p);
    return {b[5:0], w[4:0], p[4:0]};
  endfunction

  task automatic configure(input int b, input int w, input logic [2:0] m, input logic inv);
    @(negedge clk);
    phy_en = 1'b0; cfg_next = mk_cfg(b, w, 3); mode_sel = m; tx_invert = inv;
    @(negedge clk);
    phy_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(ir_tx == 1'b0, "R1 ir_tx", ir_tx, 0);
    chk(in_ready == 1'b0, "R1 in_ready", in_ready, 0);
    chk(cfg_active == 16'h0, "R1 cfg_active", cfg_active, 0);
    chk({cfg_err, sir_on, mir_on, fir_on} == 4'b0, "R1 status", {cfg_err, sir_on, mir_on, fir_on}, 0);
  endtask

  task automatic t_stage();
    @(negedge clk);
    cfg_next = 16'hA5C3; mode_sel = 3'b001;
    repeat (3) @(negedge clk);
    chk(cfg_active == 16'h0, "R2 no latch while low", cfg_active, 0);
    phy_en = 1'b1;
    @(negedge clk);
    chk(cfg_active == 16'hA5C3, "R2 latch on rise", cfg_active, 16'hA5C3);
    cfg_next = 16'h1234;
    repeat (3) @(negedge clk);
    chk(cfg_active == 16'hA5C3, "R2 hold while high", cfg_active, 16'hA5C3);
    phy_en = 1'b0;
    @(negedge clk);
    cfg_next = 16'h0F0F;
    @(negedge clk);
    chk(cfg_active == 16'hA5C3, "R2 hold after fall", cfg_active, 16'hA5C3);
    phy_en = 1'b1;
    @(negedge clk);
    chk(cfg_active == 16'h0F0F, "R2 second rise", cfg_active, 16'h0F0F);
  endtask

  task automatic t_status();
    tx_en = 1'b1;
    configure(0, 3, 3'b011, 1'b0);
    chk(cfg_err == 1'b1, "R3 err on two modes", cfg_err, 1);
    chk({mir_on, sir_on} == 2'b11, "R3 on bits reflect latch", {mir_on, sir_on}, 3);
    chk(in_ready == 1'b0, "R9 ready low on err", in_ready, 0);
    phy_en = 1'b0;
    @(negedge clk);
    chk(cfg_err == 1'b1, "R3 err holds", cfg_err, 1);
    chk({mir_on, sir_on} == 2'b00, "R3 on bits off", {mir_on, sir_on}, 0);
    configure(0, 3, 3'b010, 1'b0);
    chk(cfg_err == 1'b0, "R3 err clears", cfg_err, 0);
    chk({fir_on, mir_on, sir_on} == 3'b010, "R3 medium on", {fir_on, mir_on, sir_on}, 2);
    in_valid = 1'b1; in_data = 8'h00;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b0 && ir_tx == 1'b0, "R11 medium mode no take", {in_ready, ir_tx}, 0);
    in_valid = 1'b0;
    configure(0, 3, 3'b100, 1'b0);
    chk(fir_on == 1'b1 && in_ready == 1'b0, "R11 fast mode no take", {fir_on, in_ready}, 2);
  endtask

  task automatic t_enables();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      tx_en = i[0]; rx_en = i[1]; loopback = i[2];
      #1;
      chk(tx_en_st == i[0], "R4 tx status", tx_en_st, i[0]);
      chk(rx_en_st == (i[1] & (~i[0] | i[2])), "R4 rx status", rx_en_st, i[1] & (~i[0] | i[2]));
    end
    tx_en = 1'b1;
  endtask

  task automatic t_send(input logic [7:0] d, input int b, input int w, input logic inv);
    int bitlen, plen, eff, mism, rdy_bad;
    logic [9:0] fr;
    logic e;
    configure(b, w, 3'b001, inv);
    tx_en = 1'b1;
    chk(ir_tx == inv, "R8 idle level", ir_tx, inv);
    chk(in_ready == 1'b1, "R9 ready before frame", in_ready, 1);
    in_valid = 1'b1; in_data = d;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    bitlen = 16 * (b + 1);
    plen = (w + 1) * (b + 1);
    eff = (plen < bitlen) ? plen : bitlen;
    fr = {1'b1, d, 1'b0};
    mism = 0; rdy_bad = 0;
    for (int k = 0; k < 10 * bitlen; k++) begin
      e = (!fr[k / bitlen] && (k % bitlen) < eff) ^ inv;
      if (ir_tx !== e) mism++;
      if (in_ready) rdy_bad++;
      @(negedge clk);
    end
    chk(mism == 0, "R5/R6/R7/R8 waveform mismatches", mism, 0);
    chk(rdy_bad == 0, "R9 ready low in frame", rdy_bad, 0);
    chk(in_ready == 1'b1, "R9 ready after stop", in_ready, 1);
    chk(ir_tx == inv, "R5 idle after stop", ir_tx, inv);
  endtask

  task automatic t_abort();
    configure(0, 3, 3'b001, 1'b0);
    tx_en = 1'b1;
    in_valid = 1'b1; in_data = 8'h00;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (17) @(negedge clk);
    chk(ir_tx == 1'b1, "R5 pulse of data bit", ir_tx, 1);
    phy_en = 1'b0;
    @(negedge clk);
    chk(ir_tx == 1'b0, "R10 line idle after abort", ir_tx, 0);
    chk(in_ready == 1'b0, "R10 ready low after abort", in_ready, 0);
    repeat (20) @(negedge clk);
    chk(ir_tx == 1'b0, "R10 stays idle", ir_tx, 0);
    phy_en = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 ready after re-enable", in_ready, 1);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_next = '0; phy_en = 1'b0; mode_sel = '0;
    tx_en = 1'b0; rx_en = 1'b0; loopback = 1'b0; tx_invert = 1'b0;
    in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stage();
    t_status();
    t_enables();
    t_send(8'h55, 0, 3, 1'b0);
    t_send(8'hA3, 1, 2, 1'b0);
    t_send(8'h00, 2, 12, 1'b0);
    t_send(8'hF0, 0, 20, 1'b0);
    t_send(8'h3C, 0, 5, 1'b1);
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule